// File: doc/BRIEF.md
# Oversampled Serial Receiver With Error Flags

This block turns an asynchronous NRZ serial input into parallel characters. A 16x oversampling tick paces it. The block watches the idle line for a falling edge, confirms the start bit at its centre and samples each data bit at its centre. It checks the optional parity bit and the first stop bit. Each finished character, with the parity bit removed, goes into a single holding register, which the host reads.

The host sees four flags: data present, overrun, framing error and parity error. Reading the holding register clears all four. When a character completes and the previous one has not been read, the new character is dropped and the overrun flag is raised. A line held low for longer than a character (a break) produces one character with the framing flag set. The receiver then stays idle until the line returns high. The configuration inputs are sampled when each start bit is detected, so a change on them affects only later characters.

The serial input is expected to be synchronous to `clk` already. Ticks arrive as single-cycle enables on `tick16`.

Top module: `oversampled_rx`

## Requirements
- R1: A low level seen on a tick while idle begins a start bit. If the line is high on the 8th tick after that one, the start is discarded and nothing is posted.
- R2: Data bits are sampled on the 8th tick of each 16-tick bit period and stored least significant bit first into `rd_data`. The character has 5 + `cfg_wlen` bits (`cfg_wlen` = 0 gives 5 bits, 3 gives 8 bits). Unused high bits read 0, and the parity bit is never stored.
- R3: A character is posted on the tick with index 9 of the stop bit, where the first stop tick has index 0. The one exception is 5-bit words with no parity and `cfg_stop2` = 1, which use 1.5 stop bits and post on stop tick index 20. `cfg_stop2` = 1 means 2 stop bits in every other case, except 8-bit words with parity, which keep 1 stop bit.
- R4: If `stat_full` is 1 and no read happens in the posting cycle, the new character is dropped. `rd_data`, `stat_framing` and `stat_parity` keep their values, and `stat_overrun` becomes 1.
- R5: `stat_framing` is loaded with the inverse of the first stop bit's centre sample in the same cycle as `stat_full`. Each character sets or clears it on its own.
- R6: `cfg_par_en` = 1 adds one parity bit after the data. `cfg_par_mode` selects the check. With 00 (odd), an even count of ones over data plus parity is an error. With 01 (even), an odd count is an error. With 10 (mark) or 11 (space), and with parity disabled, `stat_parity` is always loaded with 0.
- R7: A pulse on `rd_data_strobe` clears `stat_full`, `stat_overrun`, `stat_framing` and `stat_parity` on the next edge. `rd_data` is left unchanged.
- R8: A continuous low line posts exactly one all-zero character with `stat_framing` = 1. With odd parity checking, `stat_parity` is also 1. No further character is started until the line has been seen high on a tick.
- R9: Lowering `rx_enable` during a character does not stop that character from being posted. While `rx_enable` is 0, no new start bit is accepted.
- R10: A pulse on `clr_overrun` clears only `stat_overrun`, unless a character is posted in the same cycle.
- R11: If a read and a post fall in the same cycle, the new character is loaded, `stat_full` stays 1 and `stat_overrun` is 0.
- R12: After reset all flags and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16x oversampling enable, one cycle wide |
| rx_line | input | 1 | Serial input, idle high |
| rx_enable | input | 1 | Allows new start bits to be accepted |
| cfg_wlen | input | 2 | Word length code, bits = 5 + code |
| cfg_stop2 | input | 1 | Long stop selection |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | 00 odd, 01 even, 10 mark, 11 space |
| rd_data_strobe | input | 1 | Host read of the holding register |
| clr_overrun | input | 1 | Synchronous clear of the overrun flag |
| rd_data | output | 8 | Holding register |
| stat_full | output | 1 | Holding register holds an unread character |
| stat_overrun | output | 1 | A character was lost |
| stat_framing | output | 1 | Stop bit of the held character was low |
| stat_parity | output | 1 | Parity of the held character failed |

## Verification
Two events can land on the same clock edge: a host read of the holding register and the posting of a new character. The bench triggers this directly. It leaves one character unread and raises the read strobe on exactly stop tick 9 of the next character. The new data must be present, the full flag must stay set and no overrun may appear. A companion case holds the read back, and the first character plus the overrun flag must be kept instead.

// File: rtl/nrx_pkg.sv
package nrx_pkg;

    localparam int DATA_W = 8;
    localparam int OSR    = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HALT
    } rx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       stop2;
        logic       par_en;
        logic [1:0] par_mode;
    } rx_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              frame_err;
        logic              par_err;
    } rx_char_t;

    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic half_stop(input rx_cfg_t c);
        return c.stop2 && (c.wlen == 2'd0) && !c.par_en;
    endfunction

    function automatic logic parity_bad(input logic en, input logic [1:0] mode,
                                        input logic ones_odd);
        logic bad;
        bad = 1'b0;
        if (en) begin
            case (mode)
                2'b00:   bad = !ones_odd;
                2'b01:   bad = ones_odd;
                default: bad = 1'b0;
            endcase
        end
        return bad;
    endfunction

endpackage

// File: rtl/nrx_framer.sv
module nrx_framer
    import nrx_pkg::*;
#(
    parameter int OVS = OSR,
    parameter int DW  = DATA_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx,
    input  logic     en,
    input  rx_cfg_t  cfg,
    output logic     post,
    output rx_char_t post_char
);
    localparam int MID = OVS / 2;
    localparam int CW  = $clog2(OVS + OVS / 4 + 1);
    localparam int BW  = $clog2(DW);
    localparam logic [CW-1:0] C_MID  = CW'(MID);
    localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] C_PSTD = CW'(MID + 1);
    localparam logic [CW-1:0] C_PLNG = CW'(OVS + OVS / 4);

    rx_state_e      st;
    rx_cfg_t        cfg_q;
    logic [CW-1:0]  cnt;
    logic [BW-1:0]  bidx;
    logic [DW-1:0]  shreg;
    logic           ones_odd;
    logic           stop_ok;
    logic [CW-1:0]  post_at;
    logic           last_bit;

    always_comb begin
        post_at  = half_stop(cfg_q) ? C_PLNG : C_PSTD;
        last_bit = (4'(bidx) == (word_bits(cfg_q.wlen) - 4'd1));
        post     = tick && (st == ST_STOP) && (cnt == post_at);
        post_char.data      = shreg;
        post_char.frame_err = !stop_ok;
        post_char.par_err   = parity_bad(cfg_q.par_en, cfg_q.par_mode, ones_odd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cfg_q    <= '0;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            ones_odd <= 1'b0;
            stop_ok  <= 1'b1;
        end else if (tick) begin
            case (st)
                ST_IDLE: begin
                    if (en && !rx) begin
                        st       <= ST_START;
                        cnt      <= CW'(1);
                        cfg_q    <= cfg;
                        shreg    <= '0;
                        bidx     <= '0;
                        ones_odd <= 1'b0;
                    end
                end
                ST_START: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == C_MID && rx) begin
                        st <= ST_IDLE;
                    end else if (cnt == C_LAST) begin
                        st  <= ST_DATA;
                        cnt <= '0;
                    end
                end
                ST_DATA: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == C_MID) begin
                        shreg[bidx] <= rx;
                        ones_odd    <= ones_odd ^ rx;
                    end
                    if (cnt == C_LAST) begin
                        cnt <= '0;
                        if (last_bit) begin
                            st <= cfg_q.par_en ? ST_PAR : ST_STOP;
                        end else begin
                            bidx <= bidx + BW'(1);
                        end
                    end
                end
                ST_PAR: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == C_MID) begin
                        ones_odd <= ones_odd ^ rx;
                    end
                    if (cnt == C_LAST) begin
                        cnt <= '0;
                        st  <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == C_MID) begin
                        stop_ok <= rx;
                    end
                    if (post) begin
                        cnt <= '0;
                        st  <= stop_ok ? ST_IDLE : ST_HALT;
                    end
                end
                ST_HALT: begin
                    if (rx) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nrx_holding.sv
module nrx_holding
    import nrx_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          post,
    input  rx_char_t      post_char,
    input  logic          rd,
    input  logic          clr_ovr,
    output logic [DW-1:0] data,
    output logic          full,
    output logic          ovr,
    output logic          fe,
    output logic          pe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
            ovr  <= 1'b0;
            fe   <= 1'b0;
            pe   <= 1'b0;
        end else if (post) begin
            if (full && !rd) begin
                ovr <= 1'b1;
            end else begin
                data <= post_char.data;
                fe   <= post_char.frame_err;
                pe   <= post_char.par_err;
                full <= 1'b1;
                ovr  <= 1'b0;
            end
        end else begin
            if (rd) begin
                full <= 1'b0;
                ovr  <= 1'b0;
                fe   <= 1'b0;
                pe   <= 1'b0;
            end
            if (clr_ovr) begin
                ovr <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/oversampled_rx.sv
module oversampled_rx
    import nrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick16,
    input  logic             rx_line,
    input  logic             rx_enable,
    input  logic [1:0]       cfg_wlen,
    input  logic             cfg_stop2,
    input  logic             cfg_par_en,
    input  logic [1:0]       cfg_par_mode,
    input  logic             rd_data_strobe,
    input  logic             clr_overrun,
    output logic [DATA_W-1:0] rd_data,
    output logic             stat_full,
    output logic             stat_overrun,
    output logic             stat_framing,
    output logic             stat_parity
);
    rx_cfg_t  cfg_w;
    logic     post_w;
    rx_char_t char_w;

    assign cfg_w = '{wlen: cfg_wlen, stop2: cfg_stop2,
                     par_en: cfg_par_en, par_mode: cfg_par_mode};

    nrx_framer #(.OVS(OSR), .DW(DATA_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .rx        (rx_line),
        .en        (rx_enable),
        .cfg       (cfg_w),
        .post      (post_w),
        .post_char (char_w)
    );

    nrx_holding #(.DW(DATA_W)) u_holding (
        .clk       (clk),
        .rst       (rst),
        .post      (post_w),
        .post_char (char_w),
        .rd        (rd_data_strobe),
        .clr_ovr   (clr_overrun),
        .data      (rd_data),
        .full      (stat_full),
        .ovr       (stat_overrun),
        .fe        (stat_framing),
        .pe        (stat_parity)
    );

endmodule

// File: rtl/nrx_checker.sv
module nrx_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          post,
    input logic          rd,
    input logic          clr,
    input logic [DW-1:0] data,
    input logic          full,
    input logic          ovr,
    input logic          fe,
    input logic          pe
);
    assert_overrun_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (post && full && !rd) |=> (ovr && $stable(data)));

    assert_overrun_held_R4: assert property (@(posedge clk) disable iff (rst)
        ovr |-> full);

    assert_errors_with_full_R5: assert property (@(posedge clk) disable iff (rst)
        (fe || pe) |-> full);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && !post) |=> (!full && !ovr && !fe && !pe));

    assert_clear_overrun_R10: assert property (@(posedge clk) disable iff (rst)
        (clr && !post) |=> !ovr);

    assert_coincident_load_R11: assert property (@(posedge clk) disable iff (rst)
        (post && rd) |=> (full && !ovr));

endmodule

bind oversampled_rx nrx_checker #(.DW(nrx_pkg::DATA_W)) u_checker (
    .clk  (clk),
    .rst  (rst),
    .post (post_w),
    .rd   (rd_data_strobe),
    .clr  (clr_overrun),
    .data (rd_data),
    .full (stat_full),
    .ovr  (stat_overrun),
    .fe   (stat_framing),
    .pe   (stat_parity)
);

// File: tb/test_oversampled_rx.sv
module test_oversampled_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_enable = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic       rd_data_strobe = 1'b0;
    logic       clr_overrun = 1'b0;
    logic [7:0] rd_data;
    logic       stat_full, stat_overrun, stat_framing, stat_parity;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    logic [7:0] m_data = 8'h00;
    logic       m_full = 0, m_ovr = 0, m_fe = 0, m_pe = 0;

    always #5 clk = ~clk;

    oversampled_rx i_oversampled_rx (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_line(rx_line),
        .rx_enable(rx_enable), .cfg_wlen(cfg_wlen), .cfg_stop2(cfg_stop2),
        .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
        .rd_data_strobe(rd_data_strobe), .clr_overrun(clr_overrun),
        .rd_data(rd_data), .stat_full(stat_full), .stat_overrun(stat_overrun),
        .stat_framing(stat_framing), .stat_parity(stat_parity)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wmask(input logic [1:0] w);
        return 8'hFF >> (3 - w);
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input logic [1:0] w,
                                     input logic [1:0] mode);
        logic x = ^(d & wmask(w));
        case (mode)
            2'b00:   return ~x;
            2'b01:   return x;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic tk(input logic lvl, input logic rd);
        @(negedge clk);
        rx_line = lvl; tick16 = 1'b1; rd_data_strobe = rd;
        @(negedge clk);
        tick16 = 1'b0; rd_data_strobe = 1'b0;
    endtask

    task automatic send_head(input logic [7:0] d, input logic bad_par, input logic drop_en);
        repeat (16) tk(1'b0, 1'b0);
        for (int i = 0; i < 5 + int'(cfg_wlen); i++) begin
            repeat (16) tk(d[i], 1'b0);
            if (drop_en && i == 0) rx_enable = 1'b0;
        end
        if (cfg_par_en)
            repeat (16) tk(par_bit(d, cfg_wlen, cfg_par_mode) ^ bad_par, 1'b0);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic stop_lvl,
                              input logic rdp, input logic drop_en);
        logic lng = cfg_stop2 && cfg_wlen == 2'd0 && !cfg_par_en;
        int nst = !cfg_stop2 ? 16 : lng ? 24 : (cfg_wlen == 2'd3 && cfg_par_en) ? 16 : 32;
        int pidx = lng ? 20 : 9;
        send_head(d, bad_par, drop_en);
        for (int k = 0; k < nst; k++) tk(stop_lvl, rdp && k == pidx);
        repeat (3) tk(1'b1, 1'b0);
        if (m_full && !rdp) begin
            m_ovr = 1'b1;
        end else begin
            m_data = d & wmask(cfg_wlen);
            m_fe   = !stop_lvl;
            m_pe   = cfg_par_en && !cfg_par_mode[1] && bad_par;
            m_full = 1'b1;
            m_ovr  = 1'b0;
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " full"}, {7'd0, stat_full}, {7'd0, m_full});
        chk({req, " overrun"}, {7'd0, stat_overrun}, {7'd0, m_ovr});
        chk({req, " framing"}, {7'd0, stat_framing}, {7'd0, m_fe});
        chk({req, " parity"}, {7'd0, stat_parity}, {7'd0, m_pe});
        if (m_full) chk({req, " data"}, rd_data, m_data);
    endtask

    task automatic host_read(input string req);
        @(negedge clk);
        if (m_full) chk({req, " read data"}, rd_data, m_data);
        rd_data_strobe = 1'b1;
        @(negedge clk);
        rd_data_strobe = 1'b0;
        m_full = 0; m_ovr = 0; m_fe = 0; m_pe = 0;
        check_all("R7 after read");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 data", rd_data, 8'h00);
        check_all("R12");

        // R2 basic 8-bit character, LSB first
        send_frame(8'hA5, 0, 1, 0, 0);
        check_all("R2 8-bit");
        host_read("R2");

        // R2 5-bit word: high bits zero
        cfg_wlen = 2'd0;
        send_frame(8'hFF, 0, 1, 0, 0);
        check_all("R2 5-bit");
        host_read("R2");

        // R1 false start: low for ticks 0..7, high at tick 8
        cfg_wlen = 2'd3;
        repeat (8) tk(1'b0, 1'b0);
        repeat (40) tk(1'b1, 1'b0);
        check_all("R1 false start");
        send_frame(8'h3C, 0, 1, 0, 0);
        check_all("R1 after false start");
        host_read("R1");

        // R3 posting tick, one stop bit
        send_head(8'h5A, 0, 0);
        for (int k = 0; k < 9; k++) tk(1'b1, 1'b0);
        chk("R3 before tick 9", {7'd0, stat_full}, 8'd0);
        tk(1'b1, 1'b0);
        chk("R3 at tick 9", {7'd0, stat_full}, 8'd1);
        repeat (9) tk(1'b1, 1'b0);
        m_full = 1; m_data = 8'h5A; m_fe = 0; m_pe = 0;
        host_read("R3");

        // R3 1.5 stop bits
        cfg_wlen = 2'd0; cfg_stop2 = 1'b1;
        send_head(8'h15, 0, 0);
        for (int k = 0; k < 20; k++) tk(1'b1, 1'b0);
        chk("R3 before tick 20", {7'd0, stat_full}, 8'd0);
        tk(1'b1, 1'b0);
        chk("R3 at tick 20", {7'd0, stat_full}, 8'd1);
        repeat (6) tk(1'b1, 1'b0);
        m_full = 1; m_data = 8'h15; m_fe = 0; m_pe = 0;
        host_read("R3");
        cfg_wlen = 2'd3; cfg_stop2 = 1'b0;

        // R6 parity modes
        cfg_par_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            cfg_par_mode = 2'(m);
            send_frame(8'h47, 1, 1, 0, 0);
            check_all("R6 bad parity bit");
            host_read("R6");
            send_frame(8'h47, 0, 1, 0, 0);
            check_all("R6 good parity bit");
            host_read("R6");
        end

        // R5 framing error then a good character clears it
        cfg_par_mode = 2'd0;
        send_frame(8'h81, 0, 0, 0, 0);
        check_all("R5 missing stop");
        host_read("R5");
        send_frame(8'h82, 0, 1, 0, 0);
        check_all("R5 good follow-up");
        host_read("R5");

        // R4 overrun, then R10 clear of overrun
        send_frame(8'h11, 1, 1, 0, 0);
        send_frame(8'h22, 0, 0, 0, 0);
        check_all("R4 overrun");
        @(negedge clk); clr_overrun = 1'b1;
        @(negedge clk); clr_overrun = 1'b0;
        m_ovr = 0;
        check_all("R10 clear overrun");
        host_read("R10");

        // R11 read and post in the same cycle
        send_frame(8'h66, 0, 1, 0, 0);
        send_frame(8'h99, 0, 1, 1, 0);
        check_all("R11 coincident read");
        host_read("R11");

        // R8 continuous break with odd parity
        repeat (300) tk(1'b0, 1'b0);
        m_full = 1; m_data = 8'h00; m_fe = 1; m_pe = 1; m_ovr = 0;
        check_all("R8 break character");
        host_read("R8");
        repeat (100) tk(1'b0, 1'b0);
        check_all("R8 halted during break");
        repeat (4) tk(1'b1, 1'b0);
        send_frame(8'hC3, 0, 1, 0, 0);
        check_all("R8 resume after mark");
        host_read("R8");
        cfg_par_en = 1'b0;

        // R9 enable dropped mid-character
        send_frame(8'h7E, 0, 1, 0, 1);
        check_all("R9 in-progress completes");
        host_read("R9");
        send_head(8'h00, 0, 0);
        repeat (20) tk(1'b1, 1'b0);
        check_all("R9 disabled ignores start");
        rx_enable = 1'b1;

        // random characters
        for (int it = 0; it < 60; it++) begin
            cfg_wlen     = 2'($urandom % 4);
            cfg_stop2    = 1'($urandom % 2);
            cfg_par_en   = 1'($urandom % 2);
            cfg_par_mode = 2'($urandom % 4);
            send_frame(8'($urandom), ($urandom % 5) == 0, ($urandom % 5) != 0, 0, 0);
            check_all("R2 R4 R5 R6 random");
            if (($urandom % 4) != 0) host_read("R7 random");
            else if (($urandom % 2) != 0) begin
                @(negedge clk); clr_overrun = 1'b1;
                @(negedge clk); clr_overrun = 1'b0;
                m_ovr = 0;
                check_all("R10 random");
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule